// File: doc/BRIEF.md
# Power-Managed ADC Serial Readout Controller

This block is the host-side master of a four-wire serial link to a 12-bit converter. It drives chip select, the serial clock and the data line into the converter, and it captures the 16-bit word the converter returns. Every frame carries a control byte in its first eight clocks. The last two bits of that byte set the converter's power state. One setting makes the converter power itself down whenever chip select is high. The other keeps it powered at all times.

The controller keeps its own copy of the power state it has programmed. When the converter is powered down, it has to wake up before it samples. The controller covers this in one of two ways. It can hold the serial clock idle for a parameterised power-up interval after chip select falls. Or, when the caller asks for a fast wake, it sends a short frame that switches the converter to always-on, throws that frame's data away, and then runs the real conversion at once. Each finished conversion gives a one-cycle result strobe, the 12-bit value, and an error flag for a malformed header.

Top module: `adc_pm_reader`

## Requirements
- R1: After reset, cs_n and sclk are high, and busy, res_valid, res_err and adc_on are low.
- R2: Each cs_n low window has exactly 16 sclk rising edges. sclk idles high. mosi changes only while sclk is low. miso is sampled on rising edges, MSB first.
- R3: The first 8 bits on mosi, MSB first, are aux[5:0] followed by two power bits. The power bits are 01 for always-on (keep_on=1) and 00 for shutdown-while-deselected (keep_on=0).
- R4: When the converter is believed powered down and fast_wake=0, the first sclk falling edge comes PUP_CYC+1 clocks after cs_n falls. PUP_CYC is ceil(CLK_MHZ*PUP_NS/1000), which is 625 at the defaults.
- R5: When the converter is believed always-on, the first sclk falling edge comes 1 clock after cs_n falls.
- R6: When the converter is believed powered down and fast_wake=1, a request produces two frames with no power-up wait. The first frame has power bits 01, and its data is discarded. The second frame carries the requested power bits and gives the result.
- R7: res_valid is a one-cycle pulse 1 clock after cs_n rises at the end of the result frame. res_data then equals the low 12 bits of the captured word.
- R8: res_err is 1 with a result if any of the top 4 captured bits is nonzero. It is 0 otherwise.
- R9: cs_n stays high for at least CSH_CYC clocks between frames.
- R10: start is ignored while busy is high, which includes the whole time cs_n is low. It causes no extra frame and no extra result.
- R11: adc_on shows the power bits of the last completed result frame: 1 after 01, 0 after 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one conversion (taken when not busy) |
| keep_on | input | 1 | Power state to program with this conversion: 1 always-on, 0 shutdown |
| fast_wake | input | 1 | Wake a powered-down converter with an extra frame instead of waiting |
| aux | input | 6 | Upper six control-byte bits, sent first |
| busy | output | 1 | Request in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 12 | Conversion result |
| res_err | output | 1 | Nonzero header bits in the captured word |
| adc_on | output | 1 | Converter believed always-on |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idle high |
| mosi | output | 1 | Data to converter |
| miso | input | 1 | Data from converter |

## Verification
The bench builds the block with its default parameters: CLK_MHZ=125, PUP_NS=5000, HALF_DIV=4 and CSH_CYC=6. These give a 625-cycle power-up wait and 128-clock frames, so a full wait fits easily in the run. The bench's converter model returns a corrupted sample whenever it was powered down and the second rising edge came less than 625 clocks after chip select fell. A skipped wait or a missing wake frame therefore shows up as wrong data, and not only as a timing difference. The short 6-clock deselect time lets wake-then-convert pairs run back to back, which puts the minimum-gap rule under test.

// File: rtl/adc_pm_pkg.sv
`timescale 1ns/1ps
package adc_pm_pkg;

  localparam int FRAME_W = 16;
  localparam int CTRL_W  = 8;
  localparam int AUX_W   = 6;
  localparam int RES_W   = 12;
  localparam int LEAD_W  = FRAME_W - RES_W;

  localparam logic [1:0] PM_SHUT = 2'b00;
  localparam logic [1:0] PM_ON   = 2'b01;

  typedef enum logic [2:0] {
    E_IDLE,
    E_PRE,
    E_LO,
    E_HI,
    E_GAP
  } eng_state_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAKE_REQ,
    S_WAKE_RUN,
    S_CONV_REQ,
    S_CONV_RUN
  } seq_state_t;

  function automatic logic [CTRL_W-1:0] build_ctrl(input logic [AUX_W-1:0] a,
                                                   input logic [1:0] pm);
    return {a, pm};
  endfunction

endpackage

// File: rtl/adc_frame_engine.sv
`timescale 1ns/1ps
module adc_frame_engine
  import adc_pm_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int CSH_CYC  = 6,
  parameter int CW       = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [CTRL_W-1:0]  ctrl,
  input  logic [CW-1:0]      pre_cyc,
  output logic               ready,
  output logic               done,
  output logic [FRAME_W-1:0] word,
  output logic               cs_n,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso
);

  localparam int BW  = $clog2(FRAME_W);
  localparam int CSW = $clog2(CSH_CYC + 1) + 1;
  localparam logic [CW-1:0] HALF_M1 = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] CSH_M1  = CW'(CSH_CYC - 1);
  localparam logic [BW-1:0] LAST    = BW'(FRAME_W - 1);

  eng_state_t          st;
  logic [CW-1:0]       cnt;
  logic [BW-1:0]       bitn;
  logic [FRAME_W-1:0]  tx;
  logic [FRAME_W-1:0]  rx;

  assign ready = (st == E_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= E_IDLE;
      cs_n <= 1'b1;
      sclk <= 1'b1;
      mosi <= 1'b0;
      cnt  <= '0;
      bitn <= '0;
      tx   <= '0;
      rx   <= '0;
      done <= 1'b0;
      word <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        E_IDLE: begin
          if (go) begin
            cs_n <= 1'b0;
            tx   <= {ctrl, {(FRAME_W-CTRL_W){1'b0}}};
            mosi <= ctrl[CTRL_W-1];
            cnt  <= pre_cyc;
            bitn <= '0;
            st   <= E_PRE;
          end
        end
        E_PRE: begin
          if (cnt == '0) begin
            sclk <= 1'b0;
            cnt  <= HALF_M1;
            st   <= E_LO;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        E_LO: begin
          if (cnt == '0) begin
            sclk <= 1'b1;
            rx   <= {rx[FRAME_W-2:0], miso};
            cnt  <= HALF_M1;
            st   <= E_HI;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        E_HI: begin
          if (cnt == '0) begin
            if (bitn == LAST) begin
              cs_n <= 1'b1;
              done <= 1'b1;
              word <= rx;
              cnt  <= CSH_M1;
              st   <= E_GAP;
            end else begin
              sclk <= 1'b0;
              bitn <= bitn + 1'b1;
              tx   <= tx << 1;
              mosi <= tx[FRAME_W-2];
              cnt  <= HALF_M1;
              st   <= E_LO;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        E_GAP: begin
          if (cnt == '0) st <= E_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  // Checker state: observed rising edges per frame and deselect length
  logic           sclk_q;
  logic [BW:0]    chk_rises;
  logic [CSW-1:0] chk_high;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= 1'b1;
      chk_rises <= '0;
      chk_high  <= CSW'(CSH_CYC);
    end else begin
      sclk_q <= sclk;
      if (cs_n)                chk_rises <= '0;
      else if (sclk && !sclk_q) chk_rises <= chk_rises + 1'b1;
      if (!cs_n)                       chk_high <= '0;
      else if (chk_high < CSW'(CSH_CYC)) chk_high <= chk_high + 1'b1;
    end
  end

  // R2: data to converter holds while the clock is high inside a frame
  a_r2_mosi_stable_high: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$past(cs_n) && sclk && $past(sclk)) |-> $stable(mosi));

  // R2: sixteen rising clock edges per select window
  a_r2_sixteen_rises: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (chk_rises == (BW+1)'(FRAME_W)));

  // R9: minimum deselect time before the next frame
  a_r9_cs_high_min: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (chk_high >= CSW'(CSH_CYC)));

endmodule

// File: rtl/adc_pm_seq.sv
`timescale 1ns/1ps
module adc_pm_seq
  import adc_pm_pkg::*;
#(
  parameter int CW      = 10,
  parameter int PUP_CYC = 625
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               keep_on,
  input  logic               fast_wake,
  input  logic [AUX_W-1:0]   aux,
  input  logic               eng_ready,
  input  logic               eng_done,
  input  logic [FRAME_W-1:0] eng_word,
  output logic               go,
  output logic [CTRL_W-1:0]  ctrl,
  output logic [CW-1:0]      pre_cyc,
  output logic               busy,
  output logic               res_valid,
  output logic [RES_W-1:0]   res_data,
  output logic               res_err,
  output logic               adc_on
);

  localparam logic [CW-1:0] PUP_WAIT = CW'(PUP_CYC);

  seq_state_t        st;
  logic              keep_q;
  logic [AUX_W-1:0]  aux_q;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      keep_q    <= 1'b0;
      aux_q     <= '0;
      go        <= 1'b0;
      ctrl      <= '0;
      pre_cyc   <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_err   <= 1'b0;
      adc_on    <= 1'b0;
    end else begin
      go        <= 1'b0;
      res_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            keep_q <= keep_on;
            aux_q  <= aux;
            if (!adc_on && fast_wake) st <= S_WAKE_REQ;
            else                      st <= S_CONV_REQ;
          end
        end
        S_WAKE_REQ: begin
          if (eng_ready) begin
            go      <= 1'b1;
            ctrl    <= build_ctrl(aux_q, PM_ON);
            pre_cyc <= '0;
            st      <= S_WAKE_RUN;
          end
        end
        S_WAKE_RUN: begin
          if (eng_done) begin
            adc_on <= 1'b1;
            st     <= S_CONV_REQ;
          end
        end
        S_CONV_REQ: begin
          if (eng_ready) begin
            go      <= 1'b1;
            ctrl    <= build_ctrl(aux_q, keep_q ? PM_ON : PM_SHUT);
            pre_cyc <= adc_on ? '0 : PUP_WAIT;
            st      <= S_CONV_RUN;
          end
        end
        S_CONV_RUN: begin
          if (eng_done) begin
            res_valid <= 1'b1;
            res_data  <= eng_word[RES_W-1:0];
            res_err   <= |eng_word[FRAME_W-1:RES_W];
            adc_on    <= keep_q;
            st        <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7: result strobe lasts one cycle
  a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R10: a request seen while busy leaves the latched request unchanged
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(keep_q) && $stable(aux_q)));

  // R6: the frame after a wake frame never asks for the power-up wait
  a_r6_no_wait_after_wake: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == S_WAKE_RUN && st == S_CONV_REQ) |-> adc_on);

endmodule

// File: rtl/adc_pm_reader.sv
`timescale 1ns/1ps
module adc_pm_reader
  import adc_pm_pkg::*;
#(
  parameter int CLK_MHZ  = 125,
  parameter int PUP_NS   = 5000,
  parameter int HALF_DIV = 4,
  parameter int CSH_CYC  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             keep_on,
  input  logic             fast_wake,
  input  logic [5:0]       aux,
  output logic             busy,
  output logic             res_valid,
  output logic [11:0]      res_data,
  output logic             res_err,
  output logic             adc_on,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);

  localparam int PUP_CYC = (CLK_MHZ * PUP_NS + 999) / 1000;
  localparam int MAXCNT  = (PUP_CYC > HALF_DIV) ?
                           ((PUP_CYC > CSH_CYC) ? PUP_CYC : CSH_CYC) :
                           ((HALF_DIV > CSH_CYC) ? HALF_DIV : CSH_CYC);
  localparam int CW      = $clog2(MAXCNT + 1);

  logic               go;
  logic [CTRL_W-1:0]  ctrl;
  logic [CW-1:0]      pre_cyc;
  logic               eng_ready;
  logic               eng_done;
  logic [FRAME_W-1:0] eng_word;

  adc_pm_seq #(
    .CW      (CW),
    .PUP_CYC (PUP_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .keep_on   (keep_on),
    .fast_wake (fast_wake),
    .aux       (aux),
    .eng_ready (eng_ready),
    .eng_done  (eng_done),
    .eng_word  (eng_word),
    .go        (go),
    .ctrl      (ctrl),
    .pre_cyc   (pre_cyc),
    .busy      (busy),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_err   (res_err),
    .adc_on    (adc_on)
  );

  adc_frame_engine #(
    .HALF_DIV (HALF_DIV),
    .CSH_CYC  (CSH_CYC),
    .CW       (CW)
  ) u_eng (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .ctrl    (ctrl),
    .pre_cyc (pre_cyc),
    .ready   (eng_ready),
    .done    (eng_done),
    .word    (eng_word),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .mosi    (mosi),
    .miso    (miso)
  );

  // R10: a select window is always inside a busy request
  a_r10_busy_covers_frame: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);

endmodule

// File: tb/tb_adc_pm_reader.sv
`timescale 1ns/1ps
module tb_adc_pm_reader;

  localparam int PUP  = 625;
  localparam int CSH  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic keep_on = 1'b0;
  logic fast_wake = 1'b0;
  logic [5:0] aux = '0;
  logic busy, res_valid, res_err, adc_on, cs_n, sclk, mosi;
  logic [11:0] res_data;
  logic miso = 1'b0;

  adc_pm_reader dut (
    .clk(clk), .rst(rst), .start(start), .keep_on(keep_on),
    .fast_wake(fast_wake), .aux(aux), .busy(busy), .res_valid(res_valid),
    .res_data(res_data), .res_err(res_err), .adc_on(adc_on),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(negedge clk) cyc <= cyc + 1;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // ---------------- converter model ----------------
  logic [11:0] b_sample = '0;
  logic [3:0]  b_top = '0;
  logic [15:0] m_word = '0;
  logic [7:0]  m_din = '0;
  logic [7:0]  m_ctrl_last = '0, m_ctrl_prev = '0;
  logic [1:0]  m_pm = 2'b00;
  int m_idx = 15, m_din_n = 0, m_rises = 0, m_rises_last = 0, m_frames = 0;
  int t_fall = 0, t_rise = 0, m_gap_cur = 0, m_gap_last = 0, m_gap_prev = 0;
  int m_hi_min = 1000000, m_din_viol = 0, t_valid = 0, n_valid = 0;
  bit m_off_at_fall = 0, m_started = 0;

  always @(negedge cs_n) if (!rst) begin
    t_fall = cyc;
    if (m_frames > 0 && (cyc - t_rise) < m_hi_min) m_hi_min = cyc - t_rise;
    m_off_at_fall = (m_pm == 2'b00);
    m_word = {b_top, 12'h000};
    m_idx = 15; m_din_n = 0; m_rises = 0;
  end

  always @(negedge sclk) if (!rst && !cs_n) begin
    if (!m_started) begin m_started = 1; m_gap_cur = cyc - t_fall; end
    miso = m_word[m_idx];
    if (m_idx > 0) m_idx = m_idx - 1;
  end

  always @(posedge sclk) if (!rst && !cs_n && m_started) begin
    m_rises = m_rises + 1;
    if (m_din_n < 8) begin m_din = {m_din[6:0], mosi}; m_din_n = m_din_n + 1; end
    if (m_rises == 2) begin
      if (m_off_at_fall && (cyc - t_fall) < PUP) m_word[11:0] = 12'hBAD;
      else m_word[11:0] = b_sample;
    end
  end

  always @(posedge cs_n) if (!rst) begin
    t_rise = cyc;
    m_frames = m_frames + 1;
    m_rises_last = m_rises;
    m_ctrl_prev = m_ctrl_last; m_ctrl_last = m_din;
    m_gap_prev = m_gap_last;   m_gap_last = m_gap_cur;
    if (m_din_n == 8) m_pm = m_din[1:0];
    m_started = 0;
  end

  always @(mosi) if (!rst && !cs_n && sclk && m_started) m_din_viol = m_din_viol + 1;
  always @(posedge res_valid) t_valid = cyc;
  always @(negedge clk) if (!rst && res_valid) n_valid = n_valid + 1;

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  logic [11:0] got_data;
  logic        got_err;
  bit          got_ok;

  task automatic conv(input bit k, input bit f, input logic [5:0] a,
                      input logic [11:0] smp, input logic [3:0] top);
    int waitc;
    @(negedge clk);
    keep_on = k; fast_wake = f; aux = a; b_sample = smp; b_top = top;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_ok = 0; waitc = 0;
    while (!res_valid && waitc < 5000) begin @(negedge clk); waitc++; end
    if (res_valid) begin got_ok = 1; got_data = res_data; got_err = res_err; end
    @(negedge clk);
    chk(res_valid == 1'b0, "R7", "strobe width", res_valid, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk(cs_n == 1'b1, "R1", "cs_n", cs_n, 1);
    chk(sclk == 1'b1, "R1", "sclk", sclk, 1);
    chk(busy == 1'b0 && res_valid == 1'b0, "R1", "busy/valid", {busy, res_valid}, 0);
    chk(res_err == 1'b0 && adc_on == 1'b0, "R1", "err/on", {res_err, adc_on}, 0);
  endtask

  task automatic t_shutdown_wait(input logic [11:0] smp, input logic [5:0] a);
    int f0 = m_frames;
    conv(0, 0, a, smp, 4'h0);
    chk(got_ok, "R7", "result seen", got_ok, 1);
    chk(m_frames == f0 + 1, "R4", "frame count", m_frames - f0, 1);
    chk(m_gap_last == PUP + 1, "R4", "wait cycles", m_gap_last, PUP + 1);
    chk(got_data == smp, "R4", "sample after wait", got_data, smp);
    chk(m_ctrl_last == {a, 2'b00}, "R3", "ctrl byte shutdown", m_ctrl_last, {a, 2'b00});
    chk(m_rises_last == 16, "R2", "rising edges", m_rises_last, 16);
    chk(got_err == 1'b0, "R8", "clean header", got_err, 0);
    chk(t_valid - t_rise == 1, "R7", "strobe delay", t_valid - t_rise, 1);
    chk(adc_on == 1'b0, "R11", "mode off", adc_on, 0);
  endtask

  task automatic t_fast_wake;
    int f0 = m_frames;
    conv(1, 1, 6'h15, 12'hF0F, 4'h0);
    chk(m_frames == f0 + 2, "R6", "two frames", m_frames - f0, 2);
    chk(m_ctrl_prev == 8'h55, "R6", "wake ctrl", m_ctrl_prev, 8'h55);
    chk(m_gap_prev == 1 && m_gap_last == 1, "R6", "no wait", m_gap_prev * 1000 + m_gap_last, 1001);
    chk(got_data == 12'hF0F, "R6", "real sample", got_data, 12'hF0F);
    chk(m_hi_min >= CSH, "R9", "cs high min", m_hi_min, CSH);
    chk(adc_on == 1'b1, "R11", "mode on", adc_on, 1);
    chk(m_din_viol == 0, "R2", "mosi moved while sclk high", m_din_viol, 0);
  endtask

  task automatic t_always_on;
    int f0 = m_frames;
    conv(1, 0, 6'h3F, 12'h001, 4'h0);
    chk(m_frames == f0 + 1, "R5", "one frame", m_frames - f0, 1);
    chk(m_gap_last == 1, "R5", "no wait", m_gap_last, 1);
    chk(m_ctrl_last == 8'hFD, "R3", "ctrl byte on", m_ctrl_last, 8'hFD);
    chk(got_data == 12'h001, "R5", "sample", got_data, 12'h001);
  endtask

  task automatic t_header_err;
    conv(1, 0, 6'h00, 12'hABC, 4'b0100);
    chk(got_err == 1'b1, "R8", "err bit2", got_err, 1);
    chk(got_data == 12'hABC, "R8", "data with err", got_data, 12'hABC);
    conv(1, 0, 6'h00, 12'h800, 4'b0001);
    chk(got_err == 1'b1, "R8", "err bit0", got_err, 1);
    conv(1, 0, 6'h00, 12'hFFF, 4'b0000);
    chk(got_err == 1'b0, "R8", "err cleared", got_err, 0);
  endtask

  task automatic t_back_to_shutdown;
    conv(0, 0, 6'h01, 12'h123, 4'h0);
    chk(m_gap_last == 1, "R5", "still on for this frame", m_gap_last, 1);
    chk(m_ctrl_last == 8'h04, "R3", "ctrl byte 04", m_ctrl_last, 8'h04);
    chk(adc_on == 1'b0, "R11", "mode back off", adc_on, 0);
    t_shutdown_wait(12'h7FF, 6'h2A);
  endtask

  task automatic t_start_ignored;
    int f0 = m_frames;
    int v0 = n_valid;
    @(negedge clk);
    keep_on = 1; fast_wake = 0; aux = 6'h0A; b_sample = 12'h321; b_top = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    aux = 6'h33; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (400) @(negedge clk);
    chk(m_frames == f0 + 1, "R10", "frames", m_frames - f0, 1);
    chk(n_valid == v0 + 1, "R10", "results", n_valid - v0, 1);
    chk(m_ctrl_last == 8'h29, "R10", "first request kept", m_ctrl_last, 8'h29);
    chk(busy == 1'b0, "R10", "idle after", busy, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_shutdown_wait(12'h5A3, 6'h2A);
    t_fast_wake();
    t_always_on();
    t_header_err();
    t_back_to_shutdown();
    conv(1, 1, 6'h00, 12'h0F0, 4'h0);
    t_start_ignored();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

endmodule